// File: doc/BRIEF.md
# Dual-Bit Serial Adder/Subtracter

This block adds or subtracts two unsigned W-bit words while working through two bit positions per clock. A complete operation therefore takes W/2 clocks instead of the W clocks a single-bit serial unit needs. On a start strobe, the block splits each operand into an even-indexed stream and an odd-indexed stream. Each stream goes into its own shift register. The lowest pair of bits leaves first.

Each clock, a small arithmetic stage takes the current even and odd bits of both operands. It forms both result bits at once and keeps one carry in a flip-flop for the next pair. The result bits move into separate even and odd result shift registers. These registers are read in parallel as the interleaved result.

The stage can only add. Subtraction is done by inverting operand A as it is loaded and inverting each sum bit as it is stored, since NOT(NOT A + B) equals A − B. In that mode the final carry of the inner addition is set exactly when B exceeds A, so it is reported directly as a borrow. A one-cycle done pulse marks the end of an operation. A strobe that arrives while an operation is running is dropped.

Top module: `ser2_addsub`

## Requirements
- R1: After reset, busy, done, result and carry_out are all zero.
- R2: With sub low at the accepted start, result equals (a + b) mod 2^W and carry_out equals bit W of a + b.
- R3: With sub high at the accepted start, result equals (a − b) mod 2^W and carry_out is 1 exactly when b > a (borrow).
- R4: done rises on the W/2-th rising clock edge after the edge that accepts start. It stays high for exactly one cycle, and busy is high during exactly those W/2 cycles.
- R5: A start strobe while busy is high is ignored. The running operation finishes with the same result and timing, and the a, b and sub values sampled with that strobe have no effect.
- R6: The carry flip-flop is cleared on every accepted start. A previous operation's final carry never affects the next result, and carry_out reads 0 in the cycle after an accepted start.
- R7: While idle with no start, result and carry_out hold their values.
- R8: Changes on a, b or sub after the accepted start do not change the running operation.
- R9: A start given in the same cycle that done is high is accepted, and that new operation completes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| sub | input | 1 | 1 selects a − b, 0 selects a + b; sampled at start |
| a | input | W | Operand A, sampled at start |
| b | input | W | Operand B, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Parallel result, valid from done until the next start |
| carry_out | output | 1 | Carry (add) or borrow (subtract) of the last operation |

## Verification
The completion pulse and a fresh start strobe can fall in the same cycle. While done is high the block is already idle, so it must accept that strobe, clear its carry and begin a new run, and the earlier result must already have been read. The bench provokes this by launching a second operation in the very cycle it sees done. The first result is checked in that cycle, and the second result and its completion timing are checked afterwards. A related collision, a strobe arriving mid-run, is provoked with different operands and mode and judged by the unchanged first result.

// File: rtl/ser2_addsub.sv
module ser2_addsub #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         carry_out
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(H + 1);

  initial begin
    if (W % 2 != 0 || W < 4) $error("W must be even and at least 4");
  end

  logic [H-1:0]  a_ev, a_od, b_ev, b_od;
  logic [H-1:0]  ae_q, ao_q, be_q, bo_q;
  logic [H-1:0]  se_q, so_q;
  logic          cy_q, mode_q;
  logic [CW-1:0] cnt_q;
  logic          load, last;
  logic          s_ev, s_od, c_mid, c_nxt;

  for (genvar i = 0; i < H; i++) begin : g_split
    assign a_ev[i] = a[2*i]   ^ sub;
    assign a_od[i] = a[2*i+1] ^ sub;
    assign b_ev[i] = b[2*i];
    assign b_od[i] = b[2*i+1];
    assign result[2*i]   = se_q[i];
    assign result[2*i+1] = so_q[i];
  end

  assign load  = start && !busy;
  assign last  = (cnt_q == CW'(H - 1));

  assign s_ev  = ae_q[0] ^ be_q[0] ^ cy_q;
  assign c_mid = (ae_q[0] & be_q[0]) | (cy_q & (ae_q[0] ^ be_q[0]));
  assign s_od  = ao_q[0] ^ bo_q[0] ^ c_mid;
  assign c_nxt = (ao_q[0] & bo_q[0]) | (c_mid & (ao_q[0] ^ bo_q[0]));

  assign carry_out = cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q   <= '0;
      ao_q   <= '0;
      be_q   <= '0;
      bo_q   <= '0;
      se_q   <= '0;
      so_q   <= '0;
      cy_q   <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        ae_q   <= a_ev;
        ao_q   <= a_od;
        be_q   <= b_ev;
        bo_q   <= b_od;
        cy_q   <= 1'b0;
        mode_q <= sub;
        cnt_q  <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        ae_q  <= ae_q >> 1;
        ao_q  <= ao_q >> 1;
        be_q  <= be_q >> 1;
        bo_q  <= bo_q >> 1;
        se_q  <= {s_ev ^ mode_q, se_q[H-1:1]};
        so_q  <= {s_od ^ mode_q, so_q[H-1:1]};
        cy_q  <= c_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(H)));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && $stable(mode_q)));

  p_carry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !carry_out));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(carry_out)));
endmodule

// File: tb/ser2_addsub_tb_top.sv
module ser2_addsub_tb_top;
  localparam int W = 16;
  localparam int H = W / 2;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         busy, done, carry_out;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ser2_addsub #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .a(a), .b(b),
    .busy(busy), .done(done), .result(result), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vs);
    a = va; b = vb; sub = vs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 carry cleared", {W'(0), carry_out}, '0);
    check("R4 busy after start", {W'(0), busy}, {W'(0), 1'b1});
  endtask

  task automatic wait_done(input string req, output int k);
    k = 1;
    while (!done && k < 1000) begin
      @(negedge clk);
      k++;
      if (!done && !busy) break;
    end
    check({req, " done timing"}, (W+1)'(k), (W+1)'(H + 1));
  endtask

  task automatic expect_res(input string req, input logic [W-1:0] va, input logic [W-1:0] vb, input logic vs);
    logic [W:0] e;
    if (vs) e = {(vb > va) ? 1'b1 : 1'b0, va - vb};
    else    e = {1'b0, va} + {1'b0, vb};
    check(req, {carry_out, result}, e);
  endtask

  task automatic run_op(input string req, input logic [W-1:0] va, input logic [W-1:0] vb, input logic vs);
    int k;
    launch(va, vb, vs);
    wait_done(req, k);
    expect_res(req, va, vb, vs);
  endtask

  task automatic t_reset();
    check("R1 reset", {busy, done, carry_out, result[W-3:0]}, '0);
    check("R1 reset result", {1'b0, result}, '0);
  endtask

  task automatic t_add();
    run_op("R2 add small", 16'h0003, 16'h0005, 1'b0);
    @(negedge clk);
    check("R4 done one cycle", {W'(0), done}, '0);
    check("R4 busy low after", {W'(0), busy}, '0);
    run_op("R2 add carry", 16'hFFFF, 16'h0001, 1'b0);
    run_op("R2 add mixed", 16'hA5C3, 16'h7E19, 1'b0);
    run_op("R2 add ripple odd", 16'h5555, 16'h2AAB, 1'b0);
  endtask

  task automatic t_sub();
    run_op("R3 sub no borrow", 16'h1234, 16'h0234, 1'b1);
    run_op("R3 sub borrow", 16'h0001, 16'h0002, 1'b1);
    run_op("R3 sub equal", 16'h8000, 16'h8000, 1'b1);
    run_op("R3 sub zero minus", 16'h0000, 16'hFFFF, 1'b1);
  endtask

  task automatic t_carry_clear();
    run_op("R6 add sets carry", 16'hFFFF, 16'hFFFF, 1'b0);
    run_op("R6 next add clean", 16'h0001, 16'h0001, 1'b0);
  endtask

  task automatic t_ignore();
    int k;
    launch(16'h1111, 16'h2222, 1'b0);
    @(negedge clk);
    a = 16'hFFFF; b = 16'hFFFF; sub = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 3;
    while (!done && k < 1000) begin @(negedge clk); k++; end
    check("R5 ignored timing", (W+1)'(k), (W+1)'(H + 1));
    expect_res("R5 ignored result", 16'h1111, 16'h2222, 1'b0);
  endtask

  task automatic t_mid_change();
    int k;
    launch(16'h4000, 16'h0FFF, 1'b1);
    a = 16'h0; b = 16'h0; sub = 1'b0;
    wait_done("R8", k);
    expect_res("R8 inputs changed mid-run", 16'h4000, 16'h0FFF, 1'b1);
  endtask

  task automatic t_hold();
    logic [W:0] snap;
    run_op("R7 setup", 16'h7FFF, 16'h8001, 1'b0);
    snap = {carry_out, result};
    a = 16'h1234; b = 16'h4321; sub = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 hold idle", {carry_out, result}, snap);
  endtask

  task automatic t_back_to_back();
    int k;
    run_op("R9 first", 16'h0F0F, 16'h00F1, 1'b0);
    launch(16'h0100, 16'h0200, 1'b1);
    wait_done("R9 second", k);
    expect_res("R9 second", 16'h0100, 16'h0200, 1'b1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_carry_clear();
    t_ignore();
    t_mid_change();
    t_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule